// File: doc/BRIEF.md
# Free-Hole Placement Selector

This block keeps a small table of free memory ranges ("holes"), each held as a base address and a length. A client sends requests through a valid/ready port. An allocation request gives a size and a placement policy and gets back either the base address of the space it was given or a no-fit indication. A release request hands a range back. The block then merges that range with any free range that touches it from below or above, or it stores the range in a spare slot.

Each request is served by a scan of the table that reads one slot per clock, followed by one commit cycle that updates the table and pulses `rsp_done`. The four policies share one engine. The first-free policy takes the first fitting slot. The tightest policy takes the smallest fitting slot and the loosest policy takes the largest. The rotating policy resumes the search just past the slot used by the previous successful allocation. A request that no single hole can satisfy fails even when the total free space would be enough, and the caller keeps it for later. `SLOTS` must be a power of two (default 8); addresses and sizes are 16 bits.

Top module: `hole_place_sel`

## Requirements
- R1: After reset the table is empty, `req_ready` is 1 and `rsp_done` is 0, so any allocation returns no-fit.
- R2: With `policy` = 0 (first-free) the allocation takes the lowest-indexed valid slot whose size is at least the request.
- R3: With `policy` = 1 (tightest) the allocation takes the fitting slot of smallest size; ties go to the lower slot index.
- R4: With `policy` = 2 (loosest) the allocation takes the fitting slot of largest size; ties go to the lower slot index.
- R5: With `policy` = 3 (rotating) the search starts at the slot after the one used by the last successful allocation of any policy, wraps around the table, and takes the first fit. After reset it starts at slot 0.
- R6: On a successful allocation `rsp_addr` is the chosen hole's base. A hole used exactly is removed. Otherwise its base grows by the request and its size shrinks by the same amount, in the same slot.
- R7: An allocation that no single hole can satisfy returns `rsp_nofit` = 1 and leaves the table unchanged.
- R8: A release with no free neighbour is stored in the lowest-indexed empty slot and returns `rsp_ok` = 1.
- R9: A release merges with the hole ending at its base (below) and/or the hole starting at its end (above). When it merges below, the lower hole's slot grows. When it merges above only, the upper hole's slot takes the released base. When both sides are free, the lower hole's slot holds the union and the upper slot is freed.
- R10: A release with no free neighbour while all slots are full returns `rsp_ovf` = 1 and leaves the table unchanged.
- R11: `req_ready` is low from the accepting edge until the response. `rsp_done` is a one-cycle pulse that appears on the (SLOTS+1)-th rising edge after the accepting edge. Exactly one of `rsp_ok`, `rsp_nofit`, `rsp_ovf` is set with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_rel | input | 1 | 0 = allocate, 1 = release |
| req_size | input | 16 | Requested or released length |
| req_base | input | 16 | Base of the released range (release only) |
| policy | input | 2 | 0 first-free, 1 tightest, 2 loosest, 3 rotating |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Request succeeded |
| rsp_nofit | output | 1 | Allocation found no hole large enough |
| rsp_ovf | output | 1 | Release needed a slot and none was free |
| rsp_addr | output | 16 | Base address granted to an allocation |

## Verification
A wrong table entry does not show at once. It shows on a later request that visits that slot, as a wrong granted address, a no-fit where space exists, or an overflow where a merge was due. The bench therefore keeps a reference table and compares every response over a long mixed sequence of allocations and releases, so a corrupted slot is caught within a few requests. A wrong rotating pointer shows only under the rotating policy, as an address taken from an unexpected slot. Scan sequencing errors show at once as a strobe arriving in the wrong cycle.

// File: rtl/hps_pkg.sv
package hps_pkg;
    parameter int HPS_AW    = 16;
    parameter int HPS_SLOTS = 8;

    typedef logic [HPS_AW-1:0] addr_t;

    typedef struct packed {
        logic  vld;
        addr_t base;
        addr_t size;
    } hole_t;

    typedef enum logic [1:0] {
        POL_FIRST = 2'd0,
        POL_BEST  = 2'd1,
        POL_WORST = 2'd2,
        POL_NEXT  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

    function automatic logic hole_fits(hole_t h, addr_t need);
        return h.vld && (h.size >= need);
    endfunction

    function automatic logic hole_ends_at(hole_t h, addr_t a);
        return h.vld && (({1'b0, h.base} + {1'b0, h.size}) == {1'b0, a});
    endfunction
endpackage

// File: rtl/hps_hole_store.sv
module hps_hole_store
    import hps_pkg::*;
#(
    parameter int SLOTS = HPS_SLOTS,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output hole_t         rd_hole,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  hole_t         wr_hole,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx
);
    hole_t slot_q [SLOTS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                slot_q[i] <= wr_hole;
            end else if (clr_en && clr_idx == IW'(i)) begin
                slot_q[i].vld <= 1'b0;
            end
        end
    end

    assign rd_hole = slot_q[rd_idx];
endmodule

// File: rtl/hps_fit_scan.sv
module hps_fit_scan
    import hps_pkg::*;
#(
    parameter int SLOTS = HPS_SLOTS,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step,
    input  logic          is_rel,
    input  policy_e       pol,
    input  addr_t         need,
    input  addr_t         rbase,
    input  logic [IW-1:0] cur_idx,
    input  hole_t         cur,
    output logic          found,
    output logic [IW-1:0] sel_idx,
    output addr_t         sel_base,
    output addr_t         sel_size,
    output logic          dn_hit,
    output logic [IW-1:0] dn_idx,
    output addr_t         dn_base,
    output addr_t         dn_size,
    output logic          up_hit,
    output logic [IW-1:0] up_idx,
    output addr_t         up_size,
    output logic          fr_hit,
    output logic [IW-1:0] fr_idx
);
    logic              take, is_dn, is_up, is_fr;
    logic [HPS_AW:0]   rel_end;

    always_comb begin
        take = 1'b0;
        if (!is_rel && hole_fits(cur, need)) begin
            unique case (pol)
                POL_BEST:  take = !found || (cur.size < sel_size);
                POL_WORST: take = !found || (cur.size > sel_size);
                default:   take = !found;
            endcase
        end
        rel_end = {1'b0, rbase} + {1'b0, need};
        is_dn   = is_rel && hole_ends_at(cur, rbase);
        is_up   = is_rel && cur.vld && ({1'b0, cur.base} == rel_end);
        is_fr   = is_rel && !cur.vld;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            found <= 1'b0; sel_idx <= '0; sel_base <= '0; sel_size <= '0;
            dn_hit <= 1'b0; dn_idx <= '0; dn_base <= '0; dn_size <= '0;
            up_hit <= 1'b0; up_idx <= '0; up_size <= '0;
            fr_hit <= 1'b0; fr_idx <= '0;
        end else if (step) begin
            if (take) begin
                found    <= 1'b1;
                sel_idx  <= cur_idx;
                sel_base <= cur.base;
                sel_size <= cur.size;
            end
            if (is_dn) begin
                dn_hit  <= 1'b1;
                dn_idx  <= cur_idx;
                dn_base <= cur.base;
                dn_size <= cur.size;
            end
            if (is_up) begin
                up_hit  <= 1'b1;
                up_idx  <= cur_idx;
                up_size <= cur.size;
            end
            if (is_fr && !fr_hit) begin
                fr_hit <= 1'b1;
                fr_idx <= cur_idx;
            end
        end
    end
endmodule

// File: rtl/hole_place_sel.sv
module hole_place_sel
    import hps_pkg::*;
#(
    parameter int SLOTS = HPS_SLOTS,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_rel,
    input  logic [HPS_AW-1:0] req_size,
    input  logic [HPS_AW-1:0] req_base,
    input  logic [1:0]        policy,
    output logic              rsp_done,
    output logic              rsp_ok,
    output logic              rsp_nofit,
    output logic              rsp_ovf,
    output logic [HPS_AW-1:0] rsp_addr
);
    state_e        state_q;
    logic [IW-1:0] cnt_q, org_q, nf_q, scan_idx;
    logic          rel_q;
    policy_e       pol_q;
    addr_t         need_q, rbase_q;
    logic          accept, commit;

    hole_t         rd_hole;
    logic          wr_en, clr_en;
    logic [IW-1:0] wr_idx, clr_idx;
    hole_t         wr_hole;
    logic          c_ok, c_nofit, c_ovf;

    logic          found, dn_hit, up_hit, fr_hit;
    logic [IW-1:0] sel_idx, dn_idx, up_idx, fr_idx;
    addr_t         sel_base, sel_size, dn_base, dn_size, up_size;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign commit    = (state_q == ST_COMMIT);
    assign scan_idx  = org_q + cnt_q;

    hps_hole_store #(.SLOTS(SLOTS)) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(scan_idx), .rd_hole(rd_hole),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_hole(wr_hole),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    hps_fit_scan #(.SLOTS(SLOTS)) u_scan (
        .clk(clk), .rst(rst), .start(accept), .step(state_q == ST_SCAN),
        .is_rel(rel_q), .pol(pol_q), .need(need_q), .rbase(rbase_q),
        .cur_idx(scan_idx), .cur(rd_hole),
        .found(found), .sel_idx(sel_idx), .sel_base(sel_base), .sel_size(sel_size),
        .dn_hit(dn_hit), .dn_idx(dn_idx), .dn_base(dn_base), .dn_size(dn_size),
        .up_hit(up_hit), .up_idx(up_idx), .up_size(up_size),
        .fr_hit(fr_hit), .fr_idx(fr_idx)
    );

    // Control sequence: idle -> SLOTS scan cycles -> one commit cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            org_q   <= '0;
            rel_q   <= 1'b0;
            pol_q   <= POL_FIRST;
            need_q  <= '0;
            rbase_q <= '0;
            nf_q    <= IW'(SLOTS - 1);
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_SCAN;
                    cnt_q   <= '0;
                    rel_q   <= req_rel;
                    pol_q   <= policy_e'(policy);
                    need_q  <= req_size;
                    rbase_q <= req_base;
                    org_q   <= (!req_rel && policy_e'(policy) == POL_NEXT) ? nf_q + IW'(1) : '0;
                end
                ST_SCAN: begin
                    cnt_q <= cnt_q + IW'(1);
                    if (cnt_q == IW'(SLOTS - 1)) state_q <= ST_COMMIT;
                end
                default: begin
                    state_q <= ST_IDLE;
                    if (!rel_q && found) nf_q <= sel_idx;
                end
            endcase
        end
    end

    // Table update chosen from the scan results
    always_comb begin
        logic          w_en, c_en;
        logic [IW-1:0] w_idx, c_idx;
        hole_t         w_h;
        w_en = 1'b0; c_en = 1'b0; w_idx = '0; c_idx = '0; w_h = '0;
        c_ok = 1'b0; c_nofit = 1'b0; c_ovf = 1'b0;
        if (!rel_q) begin
            if (found) begin
                c_ok = 1'b1;
                if (sel_size == need_q) begin
                    c_en  = 1'b1;
                    c_idx = sel_idx;
                end else begin
                    w_en  = 1'b1;
                    w_idx = sel_idx;
                    w_h   = '{vld: 1'b1, base: sel_base + need_q, size: sel_size - need_q};
                end
            end else begin
                c_nofit = 1'b1;
            end
        end else if (dn_hit) begin
            c_ok  = 1'b1;
            w_en  = 1'b1;
            w_idx = dn_idx;
            w_h   = '{vld: 1'b1, base: dn_base,
                      size: dn_size + need_q + (up_hit ? up_size : addr_t'(0))};
            c_en  = up_hit;
            c_idx = up_idx;
        end else if (up_hit) begin
            c_ok  = 1'b1;
            w_en  = 1'b1;
            w_idx = up_idx;
            w_h   = '{vld: 1'b1, base: rbase_q, size: need_q + up_size};
        end else if (fr_hit) begin
            c_ok  = 1'b1;
            w_en  = 1'b1;
            w_idx = fr_idx;
            w_h   = '{vld: 1'b1, base: rbase_q, size: need_q};
        end else begin
            c_ovf = 1'b1;
        end
        wr_en   = w_en && commit;
        wr_idx  = w_idx;
        wr_hole = w_h;
        clr_en  = c_en && commit;
        clr_idx = c_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_nofit <= 1'b0;
            rsp_ovf   <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_done <= commit;
            if (commit) begin
                rsp_ok    <= c_ok;
                rsp_nofit <= c_nofit;
                rsp_ovf   <= c_ovf;
                rsp_addr  <= (!rel_q && found) ? sel_base : '0;
            end
        end
    end
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
    parameter int SLOTS = 8,
    localparam int CW = $clog2(SLOTS + 3) + 1
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic req_rel,
    input logic rsp_done,
    input logic rsp_ok,
    input logic rsp_nofit,
    input logic rsp_ovf
);
    logic [CW-1:0] lat_cnt;
    logic          op_rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_cnt  <= '0;
            op_rel_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            lat_cnt  <= CW'(1);
            op_rel_q <= req_rel;
        end else if (rsp_done) begin
            lat_cnt <= '0;
        end else if (lat_cnt != '0) begin
            lat_cnt <= lat_cnt + CW'(1);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_done)); // R1
    AST_NOFIT_ON_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_nofit) |-> !op_rel_q); // R7
    AST_NO_OVERFLOW_ON_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_ovf) |-> op_rel_q); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R11
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> ($countones({rsp_ok, rsp_nofit, rsp_ovf}) == 1)); // R11
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (lat_cnt == CW'(SLOTS + 2))); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (lat_cnt != '0 && !rsp_done) |-> !req_ready); // R11
endmodule

bind hole_place_sel hps_checker #(.SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_rel(req_rel), .rsp_done(rsp_done), .rsp_ok(rsp_ok),
    .rsp_nofit(rsp_nofit), .rsp_ovf(rsp_ovf)
);

// File: tb/sim_hole_place_sel.sv
module sim_hole_place_sel;
    localparam int CLK_NS = 10;
    localparam int NS     = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_rel = 1'b0;
    logic [15:0] req_size = '0;
    logic [15:0] req_base = '0;
    logic [1:0]  policy = '0;
    logic        rsp_done, rsp_ok, rsp_nofit, rsp_ovf;
    logic [15:0] rsp_addr;

    int checks = 0;
    int errors = 0;

    int mb [NS];
    int ms [NS];
    bit mv [NS];
    int nf;

    always #(CLK_NS / 2) clk = ~clk;

    hole_place_sel u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_rel(req_rel), .req_size(req_size), .req_base(req_base), .policy(policy),
        .rsp_done(rsp_done), .rsp_ok(rsp_ok), .rsp_nofit(rsp_nofit),
        .rsp_ovf(rsp_ovf), .rsp_addr(rsp_addr)
    );

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int i = 0; i < NS; i++) begin
            mv[i] = 1'b0; mb[i] = 0; ms[i] = 0;
        end
        nf = NS - 1;
    endfunction

    function automatic void m_alloc(input int pol, input int need, output bit ok, output int addr);
        int pick;
        int start;
        pick  = -1;
        start = (pol == 3) ? (nf + 1) % NS : 0;
        for (int k = 0; k < NS; k++) begin
            int i;
            i = (start + k) % NS;
            if (mv[i] && ms[i] >= need) begin
                if (pick < 0) pick = i;
                else if (pol == 1 && ms[i] < ms[pick]) pick = i;
                else if (pol == 2 && ms[i] > ms[pick]) pick = i;
            end
        end
        ok   = (pick >= 0);
        addr = 0;
        if (ok) begin
            addr = mb[pick];
            nf   = pick;
            if (ms[pick] == need) mv[pick] = 1'b0;
            else begin
                mb[pick] += need;
                ms[pick] -= need;
            end
        end
    endfunction

    function automatic void m_release(input int base, input int size, output bit ok);
        int dn, up, fr;
        dn = -1; up = -1; fr = -1;
        for (int i = 0; i < NS; i++) begin
            if (mv[i] && mb[i] + ms[i] == base) dn = i;
            if (mv[i] && mb[i] == base + size) up = i;
            if (!mv[i] && fr < 0) fr = i;
        end
        ok = 1'b1;
        if (dn >= 0) begin
            ms[dn] += size;
            if (up >= 0) begin
                ms[dn] += ms[up];
                mv[up] = 1'b0;
            end
        end else if (up >= 0) begin
            mb[up] = base;
            ms[up] += size;
        end else if (fr >= 0) begin
            mv[fr] = 1'b1; mb[fr] = base; ms[fr] = size;
        end else begin
            ok = 1'b0;
        end
    endfunction

    task automatic do_req(input bit rel, input int pol, input int size, input int base,
                          output bit ok, output bit nofit, output bit ovf,
                          output int addr, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_rel   = rel;
        policy    = pol[1:0];
        req_size  = size[15:0];
        req_base  = base[15:0];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_done && lat < 50) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        ok = rsp_ok; nofit = rsp_nofit; ovf = rsp_ovf; addr = int'(rsp_addr);
    endtask

    task automatic run_alloc(input int pol, input int need, input string tag,
                             output bit eok, output int ea);
        bit ok, nfit, ov;
        int a, lat;
        do_req(1'b0, pol, need, 0, ok, nfit, ov, a, lat);
        m_alloc(pol, need, eok, ea);
        chk(ok == eok && nfit == !eok && !ov, tag, int'(ok), int'(eok));
        if (eok) chk(a == ea, tag, a, ea);
        chk(lat == NS + 1, "R11 latency", lat, NS + 1);
    endtask

    task automatic run_release(input int base, input int size, input string tag, output bit eok);
        bit ok, nfit, ov;
        int a, lat;
        do_req(1'b1, 0, size, base, ok, nfit, ov, a, lat);
        m_release(base, size, eok);
        chk(ok == eok && ov == !eok && !nfit, tag, int'(ok), int'(eok));
        chk(lat == NS + 1, "R11 latency", lat, NS + 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_reset();
    endtask

    function automatic logic [15:0] lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int a;
        int cb [64];
        int cs [64];
        int nc;
        logic [15:0] lf;
        string ptag [4];
        ptag[0] = "R2 sweep"; ptag[1] = "R3 sweep"; ptag[2] = "R4 sweep"; ptag[3] = "R5 sweep";

        do_reset();
        // R1: idle after reset, empty table gives no-fit
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_done == 1'b0, "R1 done", int'(rsp_done), 0);
        run_alloc(0, 5, "R1 empty table", ok, a);
        chk(!ok, "R1 no-fit", int'(ok), 0);

        // R8: three isolated releases fill slots 0..2
        run_release(20, 30, "R8 isolated", ok);
        run_release(60, 20, "R8 isolated", ok);
        run_release(100, 40, "R8 isolated", ok);
        // R2: first-free picks 20
        run_alloc(0, 20, "R2 first-free", ok, a);
        chk(a == 20, "R2 addr", a, 20);
        run_release(20, 20, "R9 merge above", ok);
        // R3 + R6 exact removal
        run_alloc(1, 20, "R3 tightest", ok, a);
        chk(a == 60, "R3 addr", a, 60);
        run_release(60, 20, "R8 reuse lowest empty", ok);
        // R4 + R6 shrink
        run_alloc(2, 20, "R4 loosest", ok, a);
        chk(a == 100, "R4 addr", a, 100);
        run_release(100, 20, "R9 merge above", ok);
        // R7: larger than any hole although total space suffices
        run_alloc(0, 50, "R7 no single hole", ok, a);
        run_alloc(0, 30, "R7 table unchanged", ok, a);
        chk(a == 20, "R6 exact removal addr", a, 20);
        // R9 both sides, then below only
        run_release(20, 30, "R8 after removal", ok);
        run_release(50, 10, "R9 merge both", ok);
        run_release(80, 10, "R9 merge below", ok);
        run_release(90, 10, "R9 merge both", ok);
        run_alloc(3, 120, "R9 single merged hole", ok, a);
        chk(ok && a == 20, "R9 union", a, 20);

        // R10 overflow with full table
        do_reset();
        for (int i = 0; i < NS; i++) run_release(i * 20, 10, "R8 fill", ok);
        run_release(200, 10, "R10 overflow", ok);
        chk(!ok, "R10 flagged", int'(ok), 0);
        run_release(10, 5, "R9 merge while full", ok);
        run_alloc(0, 15, "R10 table unchanged", ok, a);
        chk(a == 0, "R6 exact use", a, 0);

        // R5 rotating pointer
        do_reset();
        run_release(0, 10, "R8", ok);
        run_release(20, 10, "R8", ok);
        run_release(40, 10, "R8", ok);
        run_alloc(3, 5, "R5 starts at slot 0", ok, a);
        chk(a == 0, "R5 addr", a, 0);
        run_alloc(3, 5, "R5 resumes", ok, a);
        chk(a == 20, "R5 addr", a, 20);
        run_alloc(0, 5, "R2 moves pointer", ok, a);
        run_alloc(3, 5, "R5 after first-free", ok, a);
        run_alloc(3, 5, "R5 wraps", ok, a);

        // Mixed sweep against the reference table
        do_reset();
        nc = 0;
        for (int i = 0; i < 16; i++) begin
            cb[nc] = 16 * i; cs[nc] = 16; nc++;
        end
        lf = 16'hACE1;
        for (int it = 0; it < 1500; it++) begin
            int r;
            int pol;
            lf = lfsr(lf);
            r  = int'(lf);
            if ((((r >> 1) % 2) == 0 && nc < 60) || nc == 0) begin
                pol = (r >> 2) % 4;
                run_alloc(pol, 1 + ((r >> 4) % 24), ptag[pol], ok, a);
                if (ok) begin
                    cb[nc] = a; cs[nc] = 1 + ((r >> 4) % 24); nc++;
                end
            end else begin
                int k;
                k = (r >> 5) % nc;
                run_release(cb[k], cs[k], "R9 sweep release", ok);
                if (ok) begin
                    nc--;
                    cb[k] = cb[nc];
                    cs[k] = cs[nc];
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule